// File: doc/BRIEF.md
# Receive Destination Filter and Frame Status

This block sits in the receive path of an Ethernet MAC, behind the deserialiser. It takes in the destination-address bytes at the start of each frame. It compares them against a programmable six-byte station address and returns one accept/reject decision per frame. A two-bit acceptance mode in the command byte selects the policy. The policy is one of: reject everything, accept everything, accept station plus broadcast, or accept station plus broadcast plus multicast.

When an accepted frame ends, the block forms a status byte from the end-of-frame error flags: short frame, dribble, CRC and overflow. The byte also carries an end marker and a good-frame flag. The six low bits of the command byte are per-cause interrupt enables, and they use the same bit positions as the status byte. An interrupt request is raised when any enabled cause is present. The request stays up until software reads the status.

The configuration port writes the station address bytes and the command byte. None of them can be read back.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `frameAccept`, `decisionValid`, `statusValid` and `irq` are 0, `statusByte` is 0x00, and the command byte is 0x00, so the acceptance mode is off.
- R2: With mode bits [7:6] of the command byte equal to 0b00, every frame is rejected and it produces no status update and no interrupt.
- R3: With mode 0b10, a frame is accepted only if its destination equals the station address or is broadcast. Broadcast means all 48 destination bits are one.
- R4: With mode 0b11, multicast frames are also accepted. A multicast frame is one whose first destination byte has bit 0 set.
- R5: With mode 0b01, every frame whose six destination bytes arrive is accepted.
- R6: `decisionValid` pulses for exactly one cycle, in the cycle after the sixth destination byte is sampled. `frameAccept` keeps its value until the next `frameStart` byte.
- R7: On `frameEnd` of an accepted frame, `statusByte` loads the following bits: 0x10 end (always set), 0x08 short, 0x04 dribble, 0x02 CRC, 0x01 overflow, and 0x20 ok. Ok is set only when none of the four errors is present. Bits 7:6 are zero. `statusValid` pulses in the next cycle.
- R8: A frame that was rejected, or that ends before its sixth destination byte, leaves `statusByte` and `irq` unchanged and gives no `statusValid`.
- R9: `irq` is set when the new status AND the command enable bits [5:0] is nonzero. It holds until `statusRead`. A set in the same cycle as a read wins.
- R10: Configuration writes go to these addresses: 0..5 write station address bytes 0..5, and byte 0 is compared with the first destination byte. Address 6 writes the command byte. A write to address 7 has no effect.
- R11: A `frameStart` byte in the middle of an address restarts the comparison from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW (3) | Configuration register select |
| cfgWrData | input | 8 | Configuration write data |
| frameStart | input | 1 | Marks the first destination byte of a frame |
| byteValid | input | 1 | Receive byte valid |
| byteData | input | 8 | Receive byte |
| frameEnd | input | 1 | End-of-frame pulse carrying the error flags |
| errCrc | input | 1 | CRC error at end of frame |
| errDribble | input | 1 | Dribble error at end of frame |
| errShort | input | 1 | Short frame at end of frame |
| errOverflow | input | 1 | Overflow at end of frame |
| statusRead | input | 1 | Status read strobe, clears irq |
| decisionValid | output | 1 | One-cycle pulse when the decision is made |
| frameAccept | output | 1 | Accept decision for the current frame |
| statusValid | output | 1 | One-cycle pulse when the status byte is loaded |
| statusByte | output | 8 | Status of the last accepted frame |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default of six address bytes, which gives a three-bit configuration address. That leaves exactly one unused code, 7, and the bench writes to it to show the write is dropped. Six bytes is the real Ethernet address length. With it, random station addresses, broadcast, multicast and plain unicast destinations can all be set against each of the four modes. Directed cases cover the cases random stimulus rarely reaches:
- a frame truncated after three bytes;
- a restart in the middle of an address;
- a status read landing on the same edge as a new interrupt.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_ALL    = 2'b01,
    MODE_STA_BC = 2'b10,
    MODE_STA_BM = 2'b11
  } acceptMode_e;

  localparam int ST_OK    = 5;
  localparam int ST_END   = 4;
  localparam int ST_SHORT = 3;
  localparam int ST_DRBL  = 2;
  localparam int ST_CRC   = 1;
  localparam int ST_OVER  = 0;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ADDR,
    FS_HELD
  } filtState_e;

  typedef struct packed {
    logic takeByte;
    logic firstByte;
    logic decide;
    logic clearAccept;
    logic loadStatus;
  } filtStrobe_t;
endpackage

// File: rtl/rx_filter_ctrl.sv
module rx_filter_ctrl
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             byteValid,
  input  logic             frameEnd,
  input  logic             frameAccept,
  output filtStrobe_t      strobes,
  output logic [IDX_W-1:0] byteIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  filtState_e       state, nextState;
  logic [IDX_W-1:0] byteCnt, nextCnt;

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextCnt   = byteCnt;
    byteIdx   = byteCnt;
    if (frameEnd) begin
      if (state == FS_HELD && frameAccept) strobes.loadStatus = 1'b1;
      nextState = FS_IDLE;
    end
    if (byteValid && frameStart) begin
      strobes.takeByte    = 1'b1;
      strobes.firstByte   = 1'b1;
      strobes.clearAccept = 1'b1;
      byteIdx             = '0;
      if (ADDR_BYTES == 1) begin
        strobes.decide = 1'b1;
        nextState      = FS_HELD;
      end else begin
        nextState = FS_ADDR;
        nextCnt   = IDX_W'(1);
      end
    end else if (byteValid && state == FS_ADDR && !frameEnd) begin
      strobes.takeByte = 1'b1;
      if (byteCnt == LAST_IDX) begin
        strobes.decide = 1'b1;
        nextState      = FS_HELD;
        nextCnt        = '0;
      end else begin
        nextCnt = byteCnt + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= FS_IDLE;
      byteCnt <= '0;
    end else begin
      state   <= nextState;
      byteCnt <= nextCnt;
    end
  end

  AST_NO_DECIDE_ON_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state != FS_ADDR) && !frameStart |-> !strobes.decide); // R6
  AST_STATUS_ONLY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state != FS_HELD) |-> !strobes.loadStatus); // R8
endmodule

// File: rtl/rx_filter_dp.sv
module rx_filter_dp
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int CFG_AW = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              errCrc,
  input  logic              errDribble,
  input  logic              errShort,
  input  logic              errOverflow,
  input  logic              statusRead,
  input  filtStrobe_t       strobes,
  input  logic [IDX_W-1:0]  byteIdx,
  output logic              decisionValid,
  output logic              frameAccept,
  output logic              statusValid,
  output logic [BYTE_W-1:0] statusByte,
  output logic              irq
);
  logic [BYTE_W-1:0]     staAddr [ADDR_BYTES];
  logic [BYTE_W-1:0]     cmdReg;
  logic [ADDR_BYTES-1:0] eqVec;
  logic                  byteEq, staRun, bcRun, mcFlag;
  logic                  staAll, bcAll, mcAll, acceptNow;
  logic [BYTE_W-1:0]     newStatus;
  acceptMode_e           mode;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gStation
    always_ff @(posedge clk) begin
      if (!rstN) staAddr[g] <= '0;
      else if (cfgWrEn && cfgAddr == CFG_AW'(g)) staAddr[g] <= cfgWrData;
    end
    assign eqVec[g] = (byteData == staAddr[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdReg <= '0;
    else if (cfgWrEn && cfgAddr == CFG_AW'(ADDR_BYTES)) cmdReg <= cfgWrData;
  end

  assign mode   = acceptMode_e'(cmdReg[7:6]);
  assign byteEq = eqVec[byteIdx];
  assign staAll = (strobes.firstByte ? 1'b1 : staRun) & byteEq;
  assign bcAll  = (strobes.firstByte ? 1'b1 : bcRun) & (&byteData);
  assign mcAll  = strobes.firstByte ? byteData[0] : mcFlag;

  always_comb begin
    unique case (mode)
      MODE_OFF:    acceptNow = 1'b0;
      MODE_ALL:    acceptNow = 1'b1;
      MODE_STA_BC: acceptNow = staAll | bcAll;
      MODE_STA_BM: acceptNow = staAll | bcAll | mcAll;
      default:     acceptNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staRun <= 1'b0;
      bcRun  <= 1'b0;
      mcFlag <= 1'b0;
    end else if (strobes.takeByte) begin
      staRun <= staAll;
      bcRun  <= bcAll;
      mcFlag <= mcAll;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameAccept   <= 1'b0;
      decisionValid <= 1'b0;
    end else begin
      decisionValid <= strobes.decide;
      if (strobes.decide) frameAccept <= acceptNow;
      else if (strobes.clearAccept) frameAccept <= 1'b0;
    end
  end

  always_comb begin
    newStatus           = '0;
    newStatus[ST_END]   = 1'b1;
    newStatus[ST_SHORT] = errShort;
    newStatus[ST_DRBL]  = errDribble;
    newStatus[ST_CRC]   = errCrc;
    newStatus[ST_OVER]  = errOverflow;
    newStatus[ST_OK]    = !(errShort | errDribble | errCrc | errOverflow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusByte  <= '0;
      statusValid <= 1'b0;
      irq         <= 1'b0;
    end else begin
      statusValid <= strobes.loadStatus;
      if (strobes.loadStatus) statusByte <= newStatus;
      if (strobes.loadStatus && |(newStatus[5:0] & cmdReg[5:0])) irq <= 1'b1;
      else if (statusRead) irq <= 1'b0;
    end
  end

  AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decide && mode == MODE_OFF |=> !frameAccept); // R2
  AST_DECISION_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid); // R6
  AST_OK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> statusByte[ST_END] && !(statusByte[ST_OK] && |statusByte[3:0]) && statusByte[7:6] == 2'b00); // R7
  AST_STATUS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> $past(frameAccept)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irq && !statusRead |=> irq); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> statusValid); // R9
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int CFG_AW = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              frameEnd,
  input  logic              errCrc,
  input  logic              errDribble,
  input  logic              errShort,
  input  logic              errOverflow,
  input  logic              statusRead,
  output logic              decisionValid,
  output logic              frameAccept,
  output logic              statusValid,
  output logic [7:0]        statusByte,
  output logic              irq
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  filtStrobe_t      strobes;
  logic [IDX_W-1:0] byteIdx;

  rx_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .frameEnd(frameEnd), .frameAccept(frameAccept), .strobes(strobes), .byteIdx(byteIdx)
  );

  rx_filter_dp #(.ADDR_BYTES(ADDR_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .byteData(byteData), .errCrc(errCrc), .errDribble(errDribble), .errShort(errShort),
    .errOverflow(errOverflow), .statusRead(statusRead), .strobes(strobes), .byteIdx(byteIdx),
    .decisionValid(decisionValid), .frameAccept(frameAccept), .statusValid(statusValid),
    .statusByte(statusByte), .irq(irq)
  );
endmodule

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       frameStart = 1'b0, byteValid = 1'b0, frameEnd = 1'b0;
  logic [7:0] byteData = '0;
  logic       errCrc = 1'b0, errDribble = 1'b0, errShort = 1'b0, errOverflow = 1'b0;
  logic       statusRead = 1'b0;
  logic       decisionValid, frameAccept, statusValid, irq;
  logic [7:0] statusByte;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [47:0] station;
  logic [7:0]  cmdModel;
  logic [7:0]  statusModel;
  logic        irqModel;

  always #5 clk = ~clk;

  rx_dest_filter i_rx_dest_filter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .frameStart(frameStart), .byteValid(byteValid), .byteData(byteData), .frameEnd(frameEnd),
    .errCrc(errCrc), .errDribble(errDribble), .errShort(errShort), .errOverflow(errOverflow),
    .statusRead(statusRead), .decisionValid(decisionValid), .frameAccept(frameAccept),
    .statusValid(statusValid), .statusByte(statusByte), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit refAccept(input logic [7:0] cmd, input logic [47:0] dest);
    bit sta = (dest == station);
    bit bc  = (dest == 48'hFFFF_FFFF_FFFF);
    bit mc  = dest[40];
    case (cmd[7:6])
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return sta | bc;
      default: return sta | bc | mc;
    endcase
  endfunction

  function automatic logic [7:0] refStatus(input logic [3:0] errs);
    return {2'b00, (errs == 4'd0), 1'b1, errs};
  endfunction

  task automatic cfgWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
    if (a == 3'd6) cmdModel = d;
  endtask

  task automatic sendDest(input logic [47:0] dest, input int nBytes);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk); byteValid = 1'b1; frameStart = (i == 0); byteData = dest[47-8*i -: 8];
    end
    @(negedge clk); byteValid = 1'b0; frameStart = 1'b0;
  endtask

  // called right after sendDest; errs = {short, dribble, crc, overflow}
  task automatic endFrame(input logic [3:0] errs, input bit rd, input bit accepted, input string req);
    logic [7:0] exp;
    frameEnd = 1'b1; statusRead = rd;
    {errShort, errDribble, errCrc, errOverflow} = errs;
    @(negedge clk);
    frameEnd = 1'b0; statusRead = 1'b0;
    {errShort, errDribble, errCrc, errOverflow} = 4'b0;
    exp = refStatus(errs);
    if (accepted) begin
      statusModel = exp;
      if (|(exp[5:0] & cmdModel[5:0])) irqModel = 1'b1;
      else if (rd) irqModel = 1'b0;
    end else if (rd) irqModel = 1'b0;
    chk(statusValid == accepted, {req, " statusValid"}, statusValid, accepted);
    chk(statusByte == statusModel, {req, " statusByte"}, statusByte, statusModel);
    chk(irq == irqModel, {req, " irq"}, irq, irqModel);
  endtask

  task automatic doFrame(input logic [47:0] dest, input logic [3:0] errs, input bit rd, input string req);
    bit ea = refAccept(cmdModel, dest);
    sendDest(dest, 6);
    chk(decisionValid == 1'b1, {req, " decisionValid"}, decisionValid, 1);
    chk(frameAccept == ea, {req, " frameAccept"}, frameAccept, ea);
    endFrame(errs, rd, ea, req);
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
    irqModel = 1'b0;
    chk(irq == 1'b0, "R9 read clears irq", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] dest;
    int seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    cmdModel = 8'h00; statusModel = 8'h00; irqModel = 1'b0;
    station = {$urandom} << 16 | 48'($urandom & 32'hFFFF);
    station[40] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(frameAccept == 0 && decisionValid == 0 && statusValid == 0 && irq == 0,
        "R1 reset outputs", {frameAccept, decisionValid, statusValid, irq}, 0);
    chk(statusByte == 8'h00, "R1 reset statusByte", statusByte, 0);

    for (int i = 0; i < 6; i++) cfgWrite(3'(i), station[47-8*i -: 8]);

    // R2: mode 00 (reset value) rejects own station and broadcast
    doFrame(station, 4'b0000, 1'b0, "R2 off station");
    doFrame(48'hFFFF_FFFF_FFFF, 4'b0000, 1'b0, "R2 off broadcast");

    // R3 mode 10 with all enables
    cfgWrite(3'd6, 8'hBF);
    doFrame(station, 4'b0000, 1'b0, "R3 station");
    chk(irq == 1'b1, "R9 irq raised on ok", irq, 1);
    readStatus();
    doFrame(48'hFFFF_FFFF_FFFF, 4'b0010, 1'b0, "R3 broadcast crc");
    readStatus();
    doFrame(48'h0100_5E00_0001, 4'b0000, 1'b0, "R3 multicast rejected");
    doFrame(station ^ 48'h0000_0000_0100, 4'b0000, 1'b0, "R3 other unicast rejected");

    // R10 write to unused address 7 does not touch command byte
    cfgWrite(3'd7, 8'h00);
    cmdModel = 8'hBF;
    doFrame(station, 4'b0000, 1'b0, "R10 addr7 ignored");
    readStatus();

    // R4 mode 11 adds multicast
    cfgWrite(3'd6, 8'hFF);
    doFrame(48'h0100_5E00_0001, 4'b1000, 1'b0, "R4 multicast short");
    readStatus();

    // R5 mode 01 accepts all
    cfgWrite(3'd6, 8'h40);
    doFrame(48'h0200_0000_0042, 4'b0001, 1'b0, "R5 any unicast");
    chk(irq == 1'b0, "R9 no irq when enables off", irq, 0);

    // R8 early end before sixth byte: no status
    cfgWrite(3'd6, 8'h7F);
    sendDest(station, 3);
    chk(decisionValid == 1'b0, "R8 no decision on truncated", decisionValid, 0);
    endFrame(4'b1000, 1'b0, 1'b0, "R8 truncated");

    // R11 restart mid-address
    cfgWrite(3'd6, 8'hBF);
    sendDest(48'h0400_0000_0000, 3);
    doFrame(station, 4'b0000, 1'b0, "R11 restart");
    readStatus();

    // R6 accept level holds until next start byte
    doFrame(station, 4'b0000, 1'b0, "R6 frame");
    repeat (3) @(negedge clk);
    chk(frameAccept == 1'b1 && decisionValid == 1'b0, "R6 accept held, pulse single",
        {frameAccept, decisionValid}, 2'b10);

    // R9 set wins over simultaneous read; irq currently 1
    doFrame(station, 4'b0100, 1'b1, "R9 set beats read");
    chk(irq == 1'b1, "R9 set beats read", irq, 1);
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R9 irq held", irq, 1);
    readStatus();

    // random frames
    for (int n = 0; n < 400; n++) begin
      int kind;
      if (n % 8 == 0) cfgWrite(3'd6, 8'($urandom));
      kind = $urandom % 4;
      case (kind)
        0: dest = station;
        1: dest = 48'hFFFF_FFFF_FFFF;
        2: begin dest = {$urandom, 16'($urandom)}; dest[40] = 1'b1; end
        default: begin dest = {$urandom, 16'($urandom)}; dest[40] = 1'b0; end
      endcase
      doFrame(dest, 4'($urandom), (($urandom % 4) == 0), "R3/R4/R5/R7/R9 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule